// File: doc/BRIEF.md
# Thermistor Resistance Tracker and Current Derater

This block measures an external negative-temperature-coefficient thermistor network and turns the reading into a thermal derating of LED current. An 8-bit code drives a programmable current source into the network. A single comparator bit returns and reports whether the pin voltage sits above a 1.25 V reference. The block steps the code once per sample strobe, so the pin voltage hovers around the reference. Each code step adds the conductance of one 4 MΩ resistor, so full scale (256 steps) is roughly 15.6 kΩ. A larger code therefore means a lower network resistance, which means a hotter thermistor.

The tracked code feeds two first-order low-pass filters. A fast filter removes sample noise and drives a hysteretic thermal shutdown flag. A slow filter, with a time constant of about two seconds at the intended strobe rate, drives an 8-bit dim-scale factor. That factor ramps linearly from full scale at 95 °C (code 49) down to half scale at 125 °C (code 60). The shutdown is not latched and releases below 110 °C (code 52). After reset, system power-up is held off until the tracker has had a settling window and the fast reading is below the 110 °C code.

Top module: `thermal_derater`

## Requirements
- R1: On a clock edge with `smp_en` high, `isrc_code` goes up by 1 when `comp_hi` is 1 and down by 1 when it is 0; with `smp_en` low the code does not change, whatever `comp_hi` does.
- R2: `isrc_code` saturates: it stays at 255 when stepped up and at 0 when stepped down.
- R3: The fast filter holds an accumulator with 3 fraction bits. On every strobe it adds (code·8 − acc) arithmetically shifted right by 2, using the code value from before that strobe. Its output is the accumulator rounded to nearest, (acc + 4) >> 3.
- R4: `therm_shdn` sets one cycle after the fast output reaches 60 or more. It stays set while the fast output is 52 or more, and clears one cycle after the output falls below 52. Code tracking continues while it is set.
- R5: The slow filter holds an accumulator with 5 fraction bits. It updates only on every 8th strobe (strobes 8, 16, …, counted from reset), adding (code·32 − acc) arithmetically shifted right by 4. Its output is (acc + 16) >> 5.
- R6: `dim_scale` is 255 when the slow output is 49 or less, 128 when it is 60 or more, and otherwise 255 − floor((s − 49)·127 / 11). It lags the slow output by one cycle.
- R7: `pwr_en` rises one cycle after both of these hold: 300 strobes have been counted since reset, and the fast output is below 52. Once high it stays high until reset, and a later shutdown does not clear it.
- R8: After reset: `isrc_code` = 0, `dim_scale` = 255, `therm_shdn` = 0, `pwr_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Sample strobe, one cycle wide |
| comp_hi | input | 1 | Comparator: pin voltage above reference |
| isrc_code | output | 8 | Current-source code, one step per 4 MΩ of conductance |
| dim_scale | output | 8 | LED current scale, 255 = full, 128 = half |
| therm_shdn | output | 1 | Thermal shutdown request |
| pwr_en | output | 1 | Power-up permitted |

## Verification
The code and both filter accumulators change on the edge that samples the strobe. The shutdown flag, the dim scale and the power enable are registered from the filter outputs and follow one cycle later. Internal reset is released two cycles after `rst_n` rises. The bench drives a strobe for one cycle, lets two more edges pass, and only then compares all four outputs. It compares them against an independent model built from R1 to R8 and advanced once per strobe. So every output is sampled after its last register stage has settled and before the next strobe arrives.

// File: rtl/thermtrk_pkg.sv
package thermtrk_pkg;
  localparam int CODE_W = 8;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic {
    HOT_CLEAR = 1'b0,
    HOT_TRIP  = 1'b1
  } hot_state_e;

  // one saturating step of the tracking counter
  function automatic code_t sat_step(code_t c, logic up);
    code_t r;
    if (up) r = (c == '1) ? c : code_t'(c + 1'b1);
    else    r = (c == '0) ? c : code_t'(c - 1'b1);
    return r;
  endfunction
endpackage

// File: rtl/thermtrk_tracker.sv
module thermtrk_tracker
  import thermtrk_pkg::*;
#(
  parameter int SLOW_DIV = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_en,
  input  logic  comp_hi,
  output code_t code,
  output logic  slow_en
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  code_t            code_q, code_d;
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    code_d = code_q;
    div_d  = div_q;
    if (smp_en) begin
      code_d = sat_step(code_q, comp_hi);
      div_d  = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      div_q  <= '0;
    end else begin
      code_q <= code_d;
      div_q  <= div_d;
    end
  end

  assign code    = code_q;
  assign slow_en = smp_en && (div_q == DIV_LAST);
endmodule

// File: rtl/thermtrk_iir.sv
module thermtrk_iir
  import thermtrk_pkg::*;
#(
  parameter int SHIFT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  code_t din,
  output code_t dout
);
  localparam int FRAC  = SHIFT + 1;
  localparam int ACC_W = CODE_W + FRAC;

  logic [ACC_W-1:0]      acc_q, acc_d;
  logic signed [ACC_W:0] diff, step, sum;
  logic [ACC_W:0]        rnd;

  always_comb begin
    diff  = $signed({1'b0, din, {FRAC{1'b0}}}) - $signed({1'b0, acc_q});
    step  = diff >>> SHIFT;
    sum   = $signed({1'b0, acc_q}) + step;
    acc_d = en ? sum[ACC_W-1:0] : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // round to nearest; the accumulator never exceeds full scale
  assign rnd  = {1'b0, acc_q} + (ACC_W+1)'(1 << (FRAC - 1));
  assign dout = rnd[FRAC +: CODE_W];
endmodule

// File: rtl/thermtrk_derate.sv
module thermtrk_derate
  import thermtrk_pkg::*;
#(
  parameter int START = 49,
  parameter int STOP  = 60
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t level,
  output code_t scale
);
  localparam int SPAN = STOP - START;
  localparam int FULL = (1 << CODE_W) - 1;
  localparam int HALF = 1 << (CODE_W - 1);
  localparam int DROP = FULL - HALF;

  code_t       scale_q, scale_d;
  logic [31:0] offs, prod, quo;

  always_comb begin
    offs = 32'(level) - 32'(START);
    prod = offs * 32'(DROP);
    quo  = prod / 32'(SPAN);
    if (32'(level) <= 32'(START))     scale_d = code_t'(FULL);
    else if (32'(level) >= 32'(STOP)) scale_d = code_t'(HALF);
    else                              scale_d = code_t'(32'(FULL) - quo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scale_q <= code_t'(FULL);
    else        scale_q <= scale_d;
  end

  assign scale = scale_q;
endmodule

// File: rtl/thermtrk_guard.sv
module thermtrk_guard
  import thermtrk_pkg::*;
#(
  parameter int TRIP   = 60,
  parameter int CLEAR  = 52,
  parameter int SETTLE = 300
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_en,
  input  code_t fast_lvl,
  output logic  hot,
  output logic  pwr_en
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE);

  hot_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pwr_q, pwr_d;
  logic             at_trip, below_clr, settled;

  assign at_trip   = 32'(fast_lvl) >= 32'(TRIP);
  assign below_clr = 32'(fast_lvl) <  32'(CLEAR);
  assign settled   = (cnt_q == CNT_END);

  always_comb begin
    st_d = st_q;
    if (at_trip)        st_d = HOT_TRIP;
    else if (below_clr) st_d = HOT_CLEAR;
    cnt_d = (smp_en && !settled) ? cnt_q + 1'b1 : cnt_q;
    pwr_d = pwr_q | (settled & below_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HOT_CLEAR;
      cnt_q <= '0;
      pwr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pwr_q <= pwr_d;
    end
  end

  assign hot    = (st_q == HOT_TRIP);
  assign pwr_en = pwr_q;
endmodule

// File: rtl/thermal_derater.sv
module thermal_derater
  import thermtrk_pkg::*;
#(
  parameter int FAST_SHIFT     = 2,
  parameter int SLOW_SHIFT     = 4,
  parameter int SLOW_DIV       = 8,
  parameter int SETTLE_SMP     = 300,
  parameter int DERATE_LO_CODE = 49,
  parameter int TRIP_CODE      = 60,
  parameter int CLEAR_CODE     = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              comp_hi,
  output logic [CODE_W-1:0] isrc_code,
  output logic [CODE_W-1:0] dim_scale,
  output logic              therm_shdn,
  output logic              pwr_en
);
  logic [1:0] rst_pipe;
  logic       rst_l;
  code_t      code, fast_lvl, slow_lvl;
  logic       slow_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  thermtrk_tracker #(.SLOW_DIV(SLOW_DIV)) u_trk (
    .clk(clk), .rst_n(rst_l), .smp_en(smp_en), .comp_hi(comp_hi),
    .code(code), .slow_en(slow_en)
  );

  thermtrk_iir #(.SHIFT(FAST_SHIFT)) u_fast (
    .clk(clk), .rst_n(rst_l), .en(smp_en), .din(code), .dout(fast_lvl)
  );

  thermtrk_iir #(.SHIFT(SLOW_SHIFT)) u_slow (
    .clk(clk), .rst_n(rst_l), .en(slow_en), .din(code), .dout(slow_lvl)
  );

  thermtrk_derate #(.START(DERATE_LO_CODE), .STOP(TRIP_CODE)) u_der (
    .clk(clk), .rst_n(rst_l), .level(slow_lvl), .scale(dim_scale)
  );

  thermtrk_guard #(.TRIP(TRIP_CODE), .CLEAR(CLEAR_CODE), .SETTLE(SETTLE_SMP)) u_grd (
    .clk(clk), .rst_n(rst_l), .smp_en(smp_en), .fast_lvl(fast_lvl),
    .hot(therm_shdn), .pwr_en(pwr_en)
  );

  assign isrc_code = code;
endmodule

// File: rtl/thermal_derater_chk.sv
module thermal_derater_chk #(
  parameter int TRIP  = 60,
  parameter int CLEAR = 52
) (
  input logic       clk,
  input logic       rst_l,
  input logic       smp_en,
  input logic       comp_hi,
  input logic [7:0] isrc_code,
  input logic [7:0] fast_lvl,
  input logic [7:0] dim_scale,
  input logic       therm_shdn,
  input logic       pwr_en
);
  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_l)
    smp_en && comp_hi && (isrc_code != 8'hFF) |=> isrc_code == 8'($past(isrc_code) + 8'd1));

  a_r1_step_dn: assert property (@(posedge clk) disable iff (!rst_l)
    smp_en && !comp_hi && (isrc_code != 8'h00) |=> isrc_code == 8'($past(isrc_code) - 8'd1));

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_l)
    !smp_en |=> $stable(isrc_code));

  a_r2_sat_hi: assert property (@(posedge clk) disable iff (!rst_l)
    smp_en && comp_hi && (isrc_code == 8'hFF) |=> isrc_code == 8'hFF);

  a_r2_sat_lo: assert property (@(posedge clk) disable iff (!rst_l)
    smp_en && !comp_hi && (isrc_code == 8'h00) |=> isrc_code == 8'h00);

  a_r4_trip: assert property (@(posedge clk) disable iff (!rst_l)
    (32'(fast_lvl) >= 32'(TRIP)) |=> therm_shdn);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_l)
    therm_shdn && (32'(fast_lvl) >= 32'(CLEAR)) |=> therm_shdn);

  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_l)
    dim_scale >= 8'd128);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_l)
    pwr_en |=> pwr_en);

  a_r7_cold: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(pwr_en) |-> (32'($past(fast_lvl)) < 32'(CLEAR)));
endmodule

bind thermal_derater thermal_derater_chk #(.TRIP(TRIP_CODE), .CLEAR(CLEAR_CODE)) u_chk (
  .clk(clk), .rst_l(rst_l), .smp_en(smp_en), .comp_hi(comp_hi),
  .isrc_code(isrc_code), .fast_lvl(fast_lvl), .dim_scale(dim_scale),
  .therm_shdn(therm_shdn), .pwr_en(pwr_en)
);

// File: tb/test_thermal_derater.sv
module test_thermal_derater;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_en;
  logic       comp_hi;
  logic [7:0] isrc_code, dim_scale;
  logic       therm_shdn, pwr_en;

  thermal_derater i_thermal_derater (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .comp_hi(comp_hi),
    .isrc_code(isrc_code), .dim_scale(dim_scale),
    .therm_shdn(therm_shdn), .pwr_en(pwr_en)
  );

  always #(CLK_PER/2) clk = ~clk;

  typedef struct {
    string tag;
    int    code;
    int    scale;
    bit    hot;
    bit    pwr;
  } exp_t;

  exp_t q[$];
  event ev_chk;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  // reference state built from the requirements
  int m_code, m_fast, m_slow, m_div, m_cnt;
  bit m_hot, m_pwr;

  function automatic int rnd(int acc, int f);
    return (acc + (1 << (f - 1))) >> f;
  endfunction

  function automatic int scale_of(int s);
    if (s <= 49) return 255;
    if (s >= 60) return 128;
    return 255 - ((s - 49) * 127) / 11;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(string tag);
    exp_t e;
    e.tag   = tag;
    e.code  = m_code;
    e.scale = scale_of(rnd(m_slow, 5));
    e.hot   = m_hot;
    e.pwr   = m_pwr;
    q.push_back(e);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " R1 R2 code"},     int'(isrc_code),  e.code);
        check({e.tag, " R5 R6 scale"},    int'(dim_scale),  e.scale);
        check({e.tag, " R3 R4 shutdown"}, int'(therm_shdn), int'(e.hot));
        check({e.tag, " R7 power"},       int'(pwr_en),     int'(e.pwr));
      end
    end
  end

  task automatic do_reset();
    smp_en  = 1'b0;
    comp_hi = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_code = 0; m_fast = 0; m_slow = 0; m_div = 0; m_cnt = 0;
    m_hot = 0; m_pwr = 0;
    push("R8 reset");
    ->ev_chk;
  endtask

  // one strobe with the pin modelled as: voltage high while code < target
  task automatic step(int target, string tag);
    bit c;
    int f;
    c = (m_code < target);
    @(negedge clk);
    comp_hi = c;
    smp_en  = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    m_fast += (((m_code << 3) - m_fast) >>> 2);
    if (m_div == 7) begin
      m_slow += (((m_code << 5) - m_slow) >>> 4);
      m_div = 0;
    end else m_div++;
    m_code = c ? ((m_code < 255) ? m_code + 1 : 255) : ((m_code > 0) ? m_code - 1 : 0);
    if (m_cnt < 300) m_cnt++;
    f = rnd(m_fast, 3);
    if (f >= 60) m_hot = 1;
    else if (f < 52) m_hot = 0;
    if (m_cnt >= 300 && f < 52) m_pwr = 1;
    push(tag);
    repeat (2) @(negedge clk);
    ->ev_chk;
  endtask

  task automatic run(int target, int n, string tag);
    for (int i = 0; i < n; i++) step(target, tag);
  endtask

  // comparator toggles with no strobe: nothing may move (R1)
  task automatic idle_toggle();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      comp_hi = ~comp_hi;
    end
    @(negedge clk);
    push("R1 idle");
    ->ev_chk;
  endtask

  initial begin
    do_reset();
    run(30, 400, "R7 cold start");
    idle_toggle();
    run(56, 1200, "R6 ramp midpoint");
    run(75, 600, "R4 hot trip");
    run(55, 400, "R4 hysteresis hold");
    run(45, 600, "R4 release");
    run(300, 300, "R2 top saturate");
    idle_toggle();
    run(-1, 400, "R2 bottom saturate");
    do_reset();
    run(70, 600, "R7 hot start gate");
    run(40, 200, "R7 late release");
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule